// File: doc/BRIEF.md
# Audio Register Space Decoder

This block sits between a host bus and the register file of a sound subsystem. It takes a bus address, keeps only the low 15 bits, and sorts each access into one region: per-voice channel registers, a plain storage area, a small common control area, a gap that is not served, a program area of the effect processor, or the working-register window of that processor. Writes land in a byte-wide backing store. Depending on the region, a write can also raise a notification or update some derived state. Reads return registered data, either one byte or two bytes in little-endian order.

Channel writes tell the voice engine which channel and which register offset changed. Common-area writes are handled one byte at a time. Bytes that land on the ring-buffer configuration pair update a length mask, a base address and a dirty flag. A byte that lands on the output data register is sent out as a serial-output byte with a one-cycle strobe. Program-area writes report the address of every byte they touch, so that the effect processor can reload its microcode. The working-register window is served by a separate block, so this decoder drops writes to it and reads it as zero.

Top module: `audio_regspace_decoder`

## Requirements
- R1: Only bus address bits [14:0] take part in decoding. Any higher bits are ignored, for both reads and writes.
- R2: A write below 0x2000 is stored. One cycle later it gives a single-cycle channel notification carrying chan = addr[12:7], reg = addr[6:0] and the access size (wide = 1 for 16-bit).
- R3: A read returns its data on the cycle after the request. A 16-bit read gives {byte[addr+1], byte[addr]}. A byte read gives {8'h00, byte[addr]}.
- R4: Addresses 0x2000 to 0x27FF are plain storage. Writes there raise no channel, serial-output or program notification.
- R5: Addresses 0x2800 to 0x2817 form the common area. A 16-bit write there acts as a byte write of the low data byte to addr, followed by a byte write of the high data byte to addr+1. A byte that falls on 0x2818 or above is dropped.
- R6: Any byte write to 0x2804 or 0x2805 recomputes two values from the little-endian word W at 0x2804. The length mask is (8192 << W[14:13]) - 1. The base is (W[11:0] * 2048) mod 2^21. Such a write also sets the dirty flag. The flag is cleared by the clear input, and a set wins over a clear in the same cycle.
- R7: A byte that lands on 0x280C is presented on the serial-output byte port with a valid strobe one cycle long. This holds whether the byte comes from a byte write or from either half of a 16-bit write.
- R8: A write at or above 0x3000 with address bit 1 set is dropped. It stores nothing and raises no program notification.
- R9: Writes to 0x4000 to 0x457F are not stored and raise no notification. Reads of that window return zero.
- R10: A write at or above 0x3000 outside the window, with bit 1 clear, is stored. One cycle later it pulses the program notification for addr. A 16-bit write also pulses the second lane, which stands for addr+1.
- R11: Reset clears the backing store, the read data, the derived ring values, the dirty flag and every strobe.
- R12: Only part of the space is kept: channels below CH_KEEP, the first 2^SCR_AW bytes of plain storage, the first 2^PROG_AW bytes of the program area, and the common area. Bytes outside these, and the gap 0x2818 to 0x2FFF, read as zero. Notifications still follow R2 and R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | BUS_AW | Byte address from the host |
| bus_wr | input | 1 | Write request for this cycle |
| bus_rd | input | 1 | Read request for this cycle |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data; the low byte goes to addr |
| ring_dirty_clr | input | 1 | Clears the dirty flag |
| bus_rdata | output | 16 | Registered read data |
| chw_valid | output | 1 | Channel write notification |
| chw_chan | output | 6 | Channel number of that write |
| chw_reg | output | 7 | Register offset inside the channel |
| chw_wide | output | 1 | Size of that write |
| ring_len_mask | output | 16 | Derived ring-buffer length mask |
| ring_base | output | 21 | Derived ring-buffer base address |
| ring_dirty | output | 1 | Ring configuration has changed |
| midi_valid | output | 1 | Serial-output byte strobe |
| midi_byte | output | 8 | Serial-output byte |
| prog_lo_valid | output | 1 | Program byte at prog_addr written |
| prog_hi_valid | output | 1 | Program byte at prog_addr+1 written |
| prog_addr | output | 15 | Address of the program write |

## Verification
The assertions assume that the host never raises read and write in the same cycle, and one of them checks this. They also assume that the control inputs are never unknown while out of reset. The bench drives at most one request per cycle and leaves every other cycle idle, so each strobe can be traced to exactly one request. It aims its vectors at the region boundaries, the unaligned program addresses, the common-area edge at 0x2817, and the byte and word paths into 0x2804, 0x2805 and 0x280C.

// File: rtl/arsd_pkg.sv
`timescale 1ns/1ps
package arsd_pkg;

    localparam int REG_AW    = 15;
    localparam int COM_BYTES = 24;
    localparam int COM_IW    = 5;
    localparam int RAM_AW    = 21;
    localparam int LEN_W     = 16;
    localparam int RBP_W     = 12;
    localparam int RBL_LSB   = 13;
    localparam int LEN_LG0   = 13;
    localparam int UNIT_LG   = 11;

    localparam logic [REG_AW-1:0] CHAN_END = 15'h2000;
    localparam logic [REG_AW-1:0] COM_BASE = 15'h2800;
    localparam logic [REG_AW-1:0] COM_END  = 15'h2818;
    localparam logic [REG_AW-1:0] DSP_BASE = 15'h3000;
    localparam logic [REG_AW-1:0] WIN_BASE = 15'h4000;
    localparam logic [REG_AW-1:0] WIN_END  = 15'h4580;

    localparam logic [COM_IW-1:0] RING_LO_IDX = 5'd4;
    localparam logic [COM_IW-1:0] RING_HI_IDX = 5'd5;
    localparam logic [COM_IW-1:0] MIDI_IDX    = 5'd12;

    typedef enum logic [2:0] {
        RG_CHAN, RG_SCR, RG_COM, RG_GAP, RG_PROG, RG_WIN, RG_BAD
    } region_e;

    function automatic logic in_window(input logic [REG_AW-1:0] a);
        return (a >= WIN_BASE) && (a < WIN_END);
    endfunction

    function automatic region_e classify(input logic [REG_AW-1:0] a);
        region_e r;
        if (a < CHAN_END)      r = RG_CHAN;
        else if (a < COM_BASE) r = RG_SCR;
        else if (a < COM_END)  r = RG_COM;
        else if (a < DSP_BASE) r = RG_GAP;
        else if (a[1])         r = RG_BAD;
        else if (in_window(a)) r = RG_WIN;
        else                   r = RG_PROG;
        return r;
    endfunction

    function automatic logic [LEN_W-1:0] ring_len(input logic [1:0] rbl);
        logic [LEN_W:0] t;
        t = ({{LEN_W{1'b0}}, 1'b1} << (LEN_LG0 + int'(rbl))) - 1'b1;
        return t[LEN_W-1:0];
    endfunction

    function automatic logic [RAM_AW-1:0] ring_base(input logic [RBP_W-1:0] rbp);
        logic [RAM_AW+RBP_W-1:0] t;
        t = {{RAM_AW{1'b0}}, rbp} << UNIT_LG;
        return t[RAM_AW-1:0];
    endfunction

endpackage

// File: rtl/arsd_byte_store.sv
`timescale 1ns/1ps
module arsd_byte_store #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    we,
    input  logic [AW-1:0] ad [2],
    input  logic [7:0]    wd [2],
    output logic [7:0]    rd [2]
);
    localparam int DEPTH = 2 ** AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (we[0]) mem[ad[0]] <= wd[0];
            if (we[1]) mem[ad[1]] <= wd[1];
        end
    end

    for (genvar k = 0; k < 2; k++) begin : g_rd
        assign rd[k] = mem[ad[k]];
    end
endmodule

// File: rtl/arsd_common_bank.sv
`timescale 1ns/1ps
module arsd_common_bank
    import arsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        we,
    input  logic [COM_IW-1:0] idx [2],
    input  logic [7:0]        wd [2],
    output logic [7:0]        rd [2],
    input  logic              dirty_clr,
    output logic [LEN_W-1:0]  len_mask,
    output logic [RAM_AW-1:0] base,
    output logic              dirty,
    output logic              midi_valid,
    output logic [7:0]        midi_byte
);
    logic [7:0] regs [COM_BYTES];
    logic [7:0] nxt  [COM_BYTES];
    logic       ring_hit, midi_hit;
    logic [7:0] midi_d;
    logic [15:0] word_n;
    logic       unused_word;

    // lane 0 is applied before lane 1, matching the byte order of a wide write
    always_comb begin
        nxt      = regs;
        ring_hit = 1'b0;
        midi_hit = 1'b0;
        midi_d   = midi_byte;
        for (int k = 0; k < 2; k++) begin
            if (we[k] && (idx[k] < COM_IW'(COM_BYTES))) begin
                nxt[idx[k]] = wd[k];
                if (idx[k] == RING_LO_IDX || idx[k] == RING_HI_IDX) ring_hit = 1'b1;
                if (idx[k] == MIDI_IDX) begin
                    midi_hit = 1'b1;
                    midi_d   = wd[k];
                end
            end
        end
    end

    assign word_n      = {nxt[RING_HI_IDX], nxt[RING_LO_IDX]};
    assign unused_word = word_n[15] ^ word_n[12];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < COM_BYTES; i++) regs[i] <= '0;
            len_mask   <= '0;
            base       <= '0;
            dirty      <= 1'b0;
            midi_valid <= 1'b0;
            midi_byte  <= '0;
        end else begin
            regs       <= nxt;
            midi_valid <= midi_hit;
            midi_byte  <= midi_d;
            if (ring_hit) begin
                len_mask <= ring_len(word_n[RBL_LSB +: 2]);
                base     <= ring_base(word_n[RBP_W-1:0]);
                dirty    <= 1'b1;
            end else if (dirty_clr) begin
                dirty <= 1'b0;
            end
        end
    end

    for (genvar k = 0; k < 2; k++) begin : g_rd
        assign rd[k] = (idx[k] < COM_IW'(COM_BYTES)) ? regs[idx[k]] : 8'h00;
    end

    // R6: a configuration byte write always leaves the flag set
    p_dirty_set_r6: assert property (@(posedge clk) disable iff (rst)
        ring_hit |=> dirty);
    // R6: whenever the flag is up, the mask covers at least 8 KiB
    p_len_form_r6: assert property (@(posedge clk) disable iff (rst)
        dirty |-> (&len_mask[LEN_LG0-1:0]));
    // R7: a serial-output strobe only follows a write cycle
    p_midi_src_r7: assert property (@(posedge clk) disable iff (rst)
        midi_valid |-> $past(|we));
endmodule

// File: rtl/arsd_decode.sv
`timescale 1ns/1ps
module arsd_decode
    import arsd_pkg::*;
#(
    parameter int CH_KEEP = 4,
    parameter int SCR_AW  = 9,
    parameter int PROG_AW = 10
) (
    input  logic [REG_AW-1:0] addr,
    input  logic              wr,
    input  logic              wide,
    output region_e           acc,
    output logic              wr_ok,
    output logic [REG_AW-1:0] lane_a [2],
    output logic [1:0]        ch_we,
    output logic [1:0]        scr_we,
    output logic [1:0]        com_we,
    output logic [1:0]        prog_we,
    output logic [1:0]        ch_hit,
    output logic [1:0]        scr_hit,
    output logic [1:0]        com_hit,
    output logic [1:0]        prog_hit
);
    localparam logic [REG_AW-1:0] CH_LIMIT   = REG_AW'(CH_KEEP * 128);
    localparam logic [REG_AW-1:0] SCR_LIMIT  = CHAN_END + REG_AW'(2 ** SCR_AW);
    localparam logic [REG_AW-1:0] PROG_LIMIT = DSP_BASE + REG_AW'(2 ** PROG_AW);

    assign acc   = classify(addr);
    assign wr_ok = wr && (acc == RG_CHAN || acc == RG_SCR || acc == RG_COM || acc == RG_PROG);

    for (genvar k = 0; k < 2; k++) begin : g_lane
        logic on;
        assign lane_a[k]   = addr + REG_AW'(k);
        assign on          = (k == 0) ? 1'b1 : wide;
        assign ch_hit[k]   = lane_a[k] < CH_LIMIT;
        assign scr_hit[k]  = (lane_a[k] >= CHAN_END) && (lane_a[k] < SCR_LIMIT);
        assign com_hit[k]  = (lane_a[k] >= COM_BASE) && (lane_a[k] < COM_END);
        assign prog_hit[k] = (lane_a[k] >= DSP_BASE) && (lane_a[k] < PROG_LIMIT)
                             && !in_window(lane_a[k]);
        assign ch_we[k]    = wr_ok && on && ch_hit[k];
        assign scr_we[k]   = wr_ok && on && scr_hit[k];
        assign com_we[k]   = wr_ok && on && com_hit[k];
        assign prog_we[k]  = wr_ok && on && prog_hit[k];
    end
endmodule

// File: rtl/audio_regspace_decoder.sv
`timescale 1ns/1ps
module audio_regspace_decoder
    import arsd_pkg::*;
#(
    parameter int BUS_AW  = 24,
    parameter int CH_KEEP = 4,
    parameter int SCR_AW  = 9,
    parameter int PROG_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_wide,
    input  logic [15:0]       bus_wdata,
    input  logic              ring_dirty_clr,
    output logic [15:0]       bus_rdata,
    output logic              chw_valid,
    output logic [5:0]        chw_chan,
    output logic [6:0]        chw_reg,
    output logic              chw_wide,
    output logic [15:0]       ring_len_mask,
    output logic [20:0]       ring_base,
    output logic              ring_dirty,
    output logic              midi_valid,
    output logic [7:0]        midi_byte,
    output logic              prog_lo_valid,
    output logic              prog_hi_valid,
    output logic [14:0]       prog_addr
);
    localparam int CH_AW = 7 + $clog2(CH_KEEP);

    logic [REG_AW-1:0] addr_m;
    logic              unused_hi;
    region_e           acc;
    logic              wr_ok;
    logic [REG_AW-1:0] lane_a [2];
    logic [1:0]        ch_we, scr_we, com_we, prog_we;
    logic [1:0]        ch_hit, scr_hit, com_hit, prog_hit;
    logic [7:0]        lane_wd [2];
    logic [7:0]        lane_rd [2];

    logic [CH_AW-1:0]   ch_ad   [2];
    logic [SCR_AW-1:0]  scr_ad  [2];
    logic [PROG_AW-1:0] prog_ad [2];
    logic [COM_IW-1:0]  com_ad  [2];
    logic [7:0]         ch_rd [2], scr_rd [2], prog_rd [2], com_rd [2];

    assign addr_m    = bus_addr[REG_AW-1:0];
    assign unused_hi = ^bus_addr[BUS_AW-1:REG_AW];

    arsd_decode #(.CH_KEEP(CH_KEEP), .SCR_AW(SCR_AW), .PROG_AW(PROG_AW)) u_dec (
        .addr(addr_m), .wr(bus_wr), .wide(bus_wide),
        .acc(acc), .wr_ok(wr_ok), .lane_a(lane_a),
        .ch_we(ch_we), .scr_we(scr_we), .com_we(com_we), .prog_we(prog_we),
        .ch_hit(ch_hit), .scr_hit(scr_hit), .com_hit(com_hit), .prog_hit(prog_hit)
    );

    for (genvar k = 0; k < 2; k++) begin : g_lane
        logic [REG_AW-1:0] com_off;
        assign lane_wd[k] = bus_wdata[8*k +: 8];
        assign ch_ad[k]   = lane_a[k][CH_AW-1:0];
        assign scr_ad[k]  = lane_a[k][SCR_AW-1:0];
        assign prog_ad[k] = lane_a[k][PROG_AW-1:0];
        assign com_off    = lane_a[k] - COM_BASE;
        assign com_ad[k]  = com_off[COM_IW-1:0];
        assign lane_rd[k] = ch_hit[k]   ? ch_rd[k]   :
                            scr_hit[k]  ? scr_rd[k]  :
                            com_hit[k]  ? com_rd[k]  :
                            prog_hit[k] ? prog_rd[k] : 8'h00;
    end

    arsd_byte_store #(.AW(CH_AW)) u_chan_store (
        .clk(clk), .rst(rst), .we(ch_we), .ad(ch_ad), .wd(lane_wd), .rd(ch_rd)
    );
    arsd_byte_store #(.AW(SCR_AW)) u_scr_store (
        .clk(clk), .rst(rst), .we(scr_we), .ad(scr_ad), .wd(lane_wd), .rd(scr_rd)
    );
    arsd_byte_store #(.AW(PROG_AW)) u_prog_store (
        .clk(clk), .rst(rst), .we(prog_we), .ad(prog_ad), .wd(lane_wd), .rd(prog_rd)
    );

    arsd_common_bank u_common (
        .clk(clk), .rst(rst), .we(com_we), .idx(com_ad), .wd(lane_wd), .rd(com_rd),
        .dirty_clr(ring_dirty_clr), .len_mask(ring_len_mask), .base(ring_base),
        .dirty(ring_dirty), .midi_valid(midi_valid), .midi_byte(midi_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata     <= '0;
            chw_valid     <= 1'b0;
            chw_chan      <= '0;
            chw_reg       <= '0;
            chw_wide      <= 1'b0;
            prog_lo_valid <= 1'b0;
            prog_hi_valid <= 1'b0;
            prog_addr     <= '0;
        end else begin
            if (bus_rd) begin
                bus_rdata <= in_window(addr_m) ? 16'h0000
                           : {bus_wide ? lane_rd[1] : 8'h00, lane_rd[0]};
            end
            chw_valid <= wr_ok && (acc == RG_CHAN);
            if (wr_ok && (acc == RG_CHAN)) begin
                chw_chan <= addr_m[12:7];
                chw_reg  <= addr_m[6:0];
                chw_wide <= bus_wide;
            end
            prog_lo_valid <= wr_ok && (acc == RG_PROG);
            prog_hi_valid <= wr_ok && (acc == RG_PROG) && bus_wide;
            if (wr_ok && (acc == RG_PROG)) prog_addr <= addr_m;
        end
    end

    // R3: requests are one per cycle
    p_single_op_r3: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd));
    // R2: channel notification traces back to a low-range write
    p_chw_src_r2: assert property (@(posedge clk) disable iff (rst)
        chw_valid |-> ($past(bus_wr) && ($past(addr_m) < CHAN_END)));
    p_chw_fields_r2: assert property (@(posedge clk) disable iff (rst)
        chw_valid |-> (chw_chan == $past(addr_m[12:7]) && chw_reg == $past(addr_m[6:0])));
    // R8: unaligned program writes never notify
    p_drop_unaligned_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (addr_m >= DSP_BASE) && addr_m[1]) |=> !prog_lo_valid);
    // R9: window reads come back as zero
    p_win_read_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && in_window(addr_m)) |=> (bus_rdata == 16'h0000));
    // R10: second lane only with the first, and only for wide writes
    p_prog_pair_r10: assert property (@(posedge clk) disable iff (rst)
        prog_hi_valid |-> (prog_lo_valid && $past(bus_wide)));
    // R11: nothing strobes right after reset
    p_reset_quiet_r11: assert property (@(posedge clk)
        $past(rst) |-> (!chw_valid && !prog_lo_valid && !midi_valid));
endmodule

// File: tb/test_audio_regspace_decoder.sv
`timescale 1ns/1ps
module test_audio_regspace_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_wide = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        ring_dirty_clr = 1'b0;
    logic [15:0] bus_rdata;
    logic        chw_valid, chw_wide;
    logic [5:0]  chw_chan;
    logic [6:0]  chw_reg;
    logic [15:0] ring_len_mask;
    logic [20:0] ring_base;
    logic        ring_dirty, midi_valid, prog_lo_valid, prog_hi_valid;
    logic [7:0]  midi_byte;
    logic [14:0] prog_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    audio_regspace_decoder i_audio_regspace_decoder (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wide(bus_wide), .bus_wdata(bus_wdata), .ring_dirty_clr(ring_dirty_clr),
        .bus_rdata(bus_rdata), .chw_valid(chw_valid), .chw_chan(chw_chan),
        .chw_reg(chw_reg), .chw_wide(chw_wide), .ring_len_mask(ring_len_mask),
        .ring_base(ring_base), .ring_dirty(ring_dirty), .midi_valid(midi_valid),
        .midi_byte(midi_byte), .prog_lo_valid(prog_lo_valid),
        .prog_hi_valid(prog_hi_valid), .prog_addr(prog_addr)
    );

    // {is_read, wide, addr[23:0], wdata[15:0], expected rdata[15:0]}
    localparam int NV = 31;
    localparam logic [57:0] VEC [NV] = '{
        {1'b0, 1'b1, 24'h000102, 16'hBEEF, 16'h0000}, // R2 store
        {1'b1, 1'b1, 24'h000102, 16'h0000, 16'hBEEF}, // R3 wide read
        {1'b1, 1'b0, 24'h000103, 16'h0000, 16'h00BE}, // R3 byte read
        {1'b0, 1'b0, 24'h000085, 16'h0077, 16'h0000}, // R2
        {1'b1, 1'b1, 24'h000084, 16'h0000, 16'h7700}, // R3 byte order
        {1'b0, 1'b1, 24'h808050, 16'h3C3C, 16'h0000}, // R1 high bits set
        {1'b1, 1'b1, 24'h000050, 16'h0000, 16'h3C3C}, // R1
        {1'b1, 1'b1, 24'hFF0050, 16'h0000, 16'h3C3C}, // R1
        {1'b0, 1'b1, 24'h002010, 16'h1234, 16'h0000}, // R4
        {1'b1, 1'b1, 24'h002010, 16'h0000, 16'h1234}, // R4
        {1'b0, 1'b1, 24'h002700, 16'h5555, 16'h0000}, // R12 not kept
        {1'b1, 1'b1, 24'h002700, 16'h0000, 16'h0000}, // R12
        {1'b0, 1'b1, 24'h002810, 16'hA1B2, 16'h0000}, // R5
        {1'b1, 1'b1, 24'h002810, 16'h0000, 16'hA1B2}, // R5
        {1'b0, 1'b1, 24'h002817, 16'h6655, 16'h0000}, // R5 edge
        {1'b1, 1'b1, 24'h002817, 16'h0000, 16'h0055}, // R5 high byte dropped
        {1'b0, 1'b1, 24'h002900, 16'h9999, 16'h0000}, // R12 gap
        {1'b1, 1'b1, 24'h002900, 16'h0000, 16'h0000}, // R12
        {1'b0, 1'b1, 24'h003010, 16'hCAFE, 16'h0000}, // R10
        {1'b1, 1'b1, 24'h003010, 16'h0000, 16'hCAFE}, // R10
        {1'b0, 1'b1, 24'h003011, 16'h4433, 16'h0000}, // R10 odd start
        {1'b1, 1'b1, 24'h003010, 16'h0000, 16'h33FE}, // R10
        {1'b0, 1'b1, 24'h003012, 16'h1111, 16'h0000}, // R8 dropped
        {1'b1, 1'b1, 24'h003012, 16'h0000, 16'h0044}, // R8
        {1'b0, 1'b1, 24'h004008, 16'h7777, 16'h0000}, // R9
        {1'b1, 1'b1, 24'h004008, 16'h0000, 16'h0000}, // R9
        {1'b0, 1'b0, 24'h000F00, 16'h00AB, 16'h0000}, // R12 channel 30
        {1'b1, 1'b0, 24'h000F00, 16'h0000, 16'h0000}, // R12
        {1'b0, 1'b1, 24'h005000, 16'h1234, 16'h0000}, // R12 program tail
        {1'b1, 1'b1, 24'h005000, 16'h0000, 16'h0000}, // R12
        {1'b1, 1'b1, 24'h000102, 16'h0000, 16'hBEEF}  // R3 retained
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic op(input logic rd, input logic wide,
                      input logic [23:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wide  = wide;
        bus_wdata = d;
        bus_wr    = !rd;
        bus_rd    = rd;
        @(posedge clk);
        #2;
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk);
        #2;
    endtask

    task automatic clr_dirty();
        ring_dirty_clr = 1'b1;
        @(posedge clk);
        #2;
        ring_dirty_clr = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R11 reset state
        chk("R11", "rdata", 32'(bus_rdata), 32'h0);
        chk("R11", "chw_valid", 32'(chw_valid), 32'h0);
        chk("R11", "midi_valid", 32'(midi_valid), 32'h0);
        chk("R11", "prog_lo", 32'(prog_lo_valid), 32'h0);
        chk("R11", "len", 32'(ring_len_mask), 32'h0);
        chk("R11", "base", 32'(ring_base), 32'h0);
        chk("R11", "dirty", 32'(ring_dirty), 32'h0);

        for (int i = 0; i < NV; i++) begin
            op(VEC[i][57], VEC[i][56], VEC[i][55:32], VEC[i][31:16]);
            if (VEC[i][57]) chk($sformatf("vec%0d", i), "rdata", 32'(bus_rdata), 32'(VEC[i][15:0]));
            idle();
        end

        // R2 notifications
        op(1'b0, 1'b0, 24'h000385, 16'h0011);
        chk("R2", "valid", 32'(chw_valid), 32'h1);
        chk("R2", "chan", 32'(chw_chan), 32'd7);
        chk("R2", "reg", 32'(chw_reg), 32'h05);
        chk("R2", "wide", 32'(chw_wide), 32'h0);
        idle();
        chk("R2", "pulse ends", 32'(chw_valid), 32'h0);
        op(1'b0, 1'b1, 24'h001FFE, 16'h2222);
        chk("R2", "chan top", 32'(chw_chan), 32'd63);
        chk("R2", "reg top", 32'(chw_reg), 32'h7E);
        chk("R2", "wide", 32'(chw_wide), 32'h1);
        idle();

        // R4 no side effects
        op(1'b0, 1'b1, 24'h002020, 16'h0C0C);
        chk("R4", "chw", 32'(chw_valid), 32'h0);
        chk("R4", "midi", 32'(midi_valid), 32'h0);
        chk("R4", "prog", 32'(prog_lo_valid), 32'h0);
        idle();

        // R6 derived ring values
        op(1'b0, 1'b1, 24'h002804, 16'h4123);
        chk("R6", "len", 32'(ring_len_mask), 32'h7FFF);
        chk("R6", "base", 32'(ring_base), 32'h091800);
        chk("R6", "dirty", 32'(ring_dirty), 32'h1);
        chk("R4", "no chw on common", 32'(chw_valid), 32'h0);
        idle();
        op(1'b0, 1'b0, 24'h002805, 16'h006F);
        chk("R6", "len hi byte", 32'(ring_len_mask), 32'hFFFF);
        chk("R6", "base masked", 32'(ring_base), 32'h191800);
        clr_dirty();
        chk("R6", "dirty cleared", 32'(ring_dirty), 32'h0);
        chk("R6", "len kept", 32'(ring_len_mask), 32'hFFFF);
        op(1'b0, 1'b0, 24'h002804, 16'h0000);
        chk("R6", "base low byte", 32'(ring_base), 32'h180000);
        chk("R6", "dirty again", 32'(ring_dirty), 32'h1);
        idle();

        // R5 split wide write reaching 0x2804 through its high byte
        op(1'b0, 1'b1, 24'h002803, 16'h5A11);
        chk("R5", "base via high lane", 32'(ring_base), 32'h1AD000);
        chk("R5", "len", 32'(ring_len_mask), 32'hFFFF);
        idle();
        op(1'b1, 1'b0, 24'h002803, 16'h0000);
        chk("R5", "low lane stored", 32'(bus_rdata), 32'h0011);
        idle();

        // R7 serial output
        op(1'b0, 1'b0, 24'h00280C, 16'h0091);
        chk("R7", "valid", 32'(midi_valid), 32'h1);
        chk("R7", "byte", 32'(midi_byte), 32'h91);
        idle();
        chk("R7", "pulse ends", 32'(midi_valid), 32'h0);
        op(1'b0, 1'b1, 24'h00280B, 16'h4E00);
        chk("R7", "high lane valid", 32'(midi_valid), 32'h1);
        chk("R7", "high lane byte", 32'(midi_byte), 32'h4E);
        idle();
        op(1'b0, 1'b1, 24'h00280C, 16'h1234);
        chk("R7", "low lane byte", 32'(midi_byte), 32'h34);
        idle();

        // R10 program notifications
        op(1'b0, 1'b1, 24'h003020, 16'hAAAA);
        chk("R10", "lo", 32'(prog_lo_valid), 32'h1);
        chk("R10", "hi", 32'(prog_hi_valid), 32'h1);
        chk("R10", "addr", 32'(prog_addr), 32'h3020);
        idle();
        chk("R10", "pulse ends", 32'(prog_lo_valid), 32'h0);
        op(1'b0, 1'b0, 24'h003021, 16'h00BB);
        chk("R10", "byte lo", 32'(prog_lo_valid), 32'h1);
        chk("R10", "byte hi", 32'(prog_hi_valid), 32'h0);
        chk("R10", "byte addr", 32'(prog_addr), 32'h3021);
        idle();
        op(1'b0, 1'b1, 24'h005000, 16'h0101);
        chk("R12", "tail still notifies", 32'(prog_lo_valid), 32'h1);
        idle();
        op(1'b0, 1'b1, 24'h003022, 16'h0202);
        chk("R8", "no notify", 32'(prog_lo_valid), 32'h0);
        idle();
        op(1'b0, 1'b1, 24'h004100, 16'h0303);
        chk("R9", "no notify", 32'(prog_lo_valid), 32'h0);
        idle();

        // R11 reset in mid-run
        rst = 1'b1;
        idle();
        idle();
        rst = 1'b0;
        chk("R11", "len", 32'(ring_len_mask), 32'h0);
        chk("R11", "dirty", 32'(ring_dirty), 32'h0);
        op(1'b1, 1'b1, 24'h000102, 16'h0000);
        chk("R11", "channel cleared", 32'(bus_rdata), 32'h0);
        idle();
        op(1'b1, 1'b1, 24'h002810, 16'h0000);
        chk("R11", "common cleared", 32'(bus_rdata), 32'h0);
        idle();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule